// File: doc/BRIEF.md
# Button Press One-Shot Controller

This block turns a clean, synchronous push-button level into a single output pulse that lasts exactly one clock cycle, however long the button is held. Once it has fired, the controller does not fire again until the button has been seen released for at least one clock edge. A new press after that release produces a new pulse.

It is a Moore machine with a two-bit state register. There are three states: waiting for a press, emitting the pulse, and waiting for release. The output comes from the state register alone, so it changes only at a rising clock edge. A synchronous, active-high reset returns the machine to the waiting state. The input must already be synchronised to the clock and free of contact bounce.

Top module: `press_pulse`

## Requirements
- R1: While `rst` is 1 at a rising edge, the next state is the waiting state, so `pulse_out` is 0 in the following cycle even if `btn_in` is held at 1. When reset is released with the button still held, the first edge that samples `btn_in`=1 produces a pulse.
- R2: From the waiting state, an edge that samples `btn_in`=1 makes `pulse_out` 1 for the cycle after that edge.
- R3: `pulse_out` is never 1 for two consecutive cycles. While `btn_in` stays at 1 after a pulse, `pulse_out` stays at 0.
- R4: One edge that samples `btn_in`=0 re-arms the controller, so a later press produces a new pulse. The pattern 1,0,1 therefore gives two pulses.
- R5: An edge that samples `btn_in`=0 is always followed by a cycle with `pulse_out`=0.
- R6: `pulse_out` changes only at a rising clock edge. A change of `btn_in` between edges leaves it unchanged. The state encoding is waiting=00, pulse=01 and release-wait=10. Code 11 is never entered, and if it were, the next state would be waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_in | input | 1 | Clean, synchronous button level |
| pulse_out | output | 1 | One-cycle pulse per press |

## Verification
The hardest case to reach from the ports is a press that arrives in the only cycle where the button was released between two presses. The machine must re-arm from the pulse state as well as from the release-wait state. The bench gets there by sweeping every 10-cycle button pattern after reset. This covers every short gap, every long hold and every back-to-back combination, and each output is compared against an arithmetic "armed" model. The unused code 11 cannot be reached through the ports at all, so a bound checker watches the state register and asserts that the code never appears.

// File: rtl/press_pulse.sv
module press_pulse (
  input  logic clk,
  input  logic rst,
  input  logic btn_in,
  output logic pulse_out
);

  localparam logic [1:0] ST_ARM  = 2'b00;
  localparam logic [1:0] ST_FIRE = 2'b01;
  localparam logic [1:0] ST_HOLD = 2'b10;

  logic [1:0] state;
  logic [1:0] state_nx;

  always_comb begin
    case (state)
      ST_ARM:  state_nx = btn_in ? ST_FIRE : ST_ARM;
      ST_FIRE: state_nx = btn_in ? ST_HOLD : ST_ARM;
      ST_HOLD: state_nx = btn_in ? ST_HOLD : ST_ARM;
      default: state_nx = ST_ARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ARM;
    else     state <= state_nx;
  end

  assign pulse_out = ~state[1] & state[0];

endmodule

module press_pulse_chk (
  input logic       clk,
  input logic       rst,
  input logic       btn_in,
  input logic       pulse_out,
  input logic [1:0] state
);

  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (state == 2'b00 && !pulse_out));

  a_r2_press_fires: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00 && btn_in) |=> pulse_out);

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out);

  a_r4_release_rearms: assert property (@(posedge clk) disable iff (rst)
    !btn_in |=> (state == 2'b00));

  a_r5_low_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !btn_in |=> !pulse_out);

  a_r6_legal_code: assert property (@(posedge clk) disable iff (rst)
    state != 2'b11);

endmodule

bind press_pulse press_pulse_chk u_chk (
  .clk(clk), .rst(rst), .btn_in(btn_in), .pulse_out(pulse_out), .state(state)
);

// File: tb/sim_press_pulse.sv
`timescale 1ns/1ps
module sim_press_pulse;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_in = 1'b0;
  logic pulse_out;
  int checks = 0;
  int errors = 0;

  press_pulse u0 (.clk(clk), .rst(rst), .btn_in(btn_in), .pulse_out(pulse_out));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_seq(input logic [9:0] s);
    logic armed;
    logic exp;
    bit fired;
    rst = 1'b1; btn_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", pulse_out, 1'b0);
    rst = 1'b0;
    armed = 1'b1;
    fired = 1'b0;
    for (int i = 0; i < 10; i++) begin
      btn_in = s[i];
      @(negedge clk);
      exp = armed & s[i];
      armed = ~s[i];
      if (exp && fired)            chk("R4", pulse_out, exp);
      else if (exp)                chk("R2", pulse_out, exp);
      else if (!s[i])              chk("R5", pulse_out, exp);
      else                         chk("R3", pulse_out, exp);
      if (exp) fired = 1'b1;
    end
  endtask

  initial begin
    logic held;
    rst = 1'b1; btn_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", pulse_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", pulse_out, 1'b1);
    @(negedge clk);
    chk("R3", pulse_out, 1'b0);

    // R6: mid-cycle input changes do not move the output
    btn_in = 1'b0;
    @(negedge clk);
    btn_in = 1'b1;
    @(negedge clk);
    held = pulse_out;
    chk("R2", held, 1'b1);
    btn_in = 1'b0; #0.5;
    chk("R6", pulse_out, held);
    btn_in = 1'b1; #0.5;
    chk("R6", pulse_out, held);
    @(negedge clk);
    held = pulse_out;
    chk("R3", held, 1'b0);
    btn_in = 1'b0; #0.7;
    chk("R6", pulse_out, held);

    for (int v = 0; v < 1024; v++) run_seq(v[9:0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule